// File: doc/BRIEF.md
# Tag-Packing FIFO Port

This block sits between a 32-bit host data port and a serial bus engine that consumes and produces 16-bit tagged entries and raw received bytes. On the transmit side the host stores words that each hold one or two entries. The engine takes them one at a time, low half first. On the receive side the engine pushes bytes. Each host read returns up to two of them, spread across the two 16-bit halves of the word. A repack control selects pair packing. With it cleared, every word moves a single entry or byte.

The queue depth is fixed at build time from two size codes. A 2-bit block code picks 4, 16 or 32 bus words per block, and a block holds half that many data entries because each byte travels with a tag. A 3-bit code n scales the depth to block entries times (2 << n). When the host announces a transfer, the port compares its length with the depth and chooses either queue mode or block mode. In block mode a service pulse marks each completed block of drained or received entries.

Top module: `tag_pack_port`

## Requirements
- R1: With repack enabled and a pair write, bits [15:0] of the host word reach the engine before bits [31:16].
- R2: A write flagged single stores only bits [15:0]. Bits [31:16] are discarded.
- R3: With repack disabled, each write stores one entry from bits [15:0] and each read removes one byte, returned in bits [7:0] with bits [23:16] zero.
- R4: status bit 6 (transmit full) is set when fewer than two slots are free (repack on) or no slot is free (repack off). A write made while it is set is dropped.
- R5: status bit 4 is high while the transmit queue holds an entry, and status bit 5 is high while the receive queue holds a byte. All other status bits are zero.
- R6: A read returns the oldest byte in bits [7:0] and the next one in bits [23:16], then removes both. With only one byte stored, bits [23:16] are zero and one byte is removed. Bits [31:24] and [15:8] are always zero.
- R7: Depth is (block words / 2) * (2 << n), with block code 0, 1, 2 giving 4, 16, 32 words.
- R8: On start, a write of B bytes selects block mode when B + 1 >= depth, and a read of B bytes when B >= depth. Otherwise queue mode is selected. blk_mode shows the choice.
- R9: In block mode, out_svc pulses for one cycle after every (block words / 2)-th entry the engine pops since start. It stays low in queue mode.
- R10: In block mode, in_svc pulses for one cycle after every (block words / 2)-th byte the engine pushes since start. It stays low in queue mode.
- R11: After reset both queues are empty, status is zero, blk_mode is low and no service pulse is present.
- R12: in_full is high when the receive queue is at depth, and a push made while it is high is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| repack_en | input | 1 | Two entries or bytes per host word when high |
| start | input | 1 | Transfer announcement strobe |
| start_is_read | input | 1 | Announced transfer is a read |
| start_bytes | input | 9 | Byte count of announced transfer |
| host_wr | input | 1 | Host write strobe |
| host_wr_single | input | 1 | Written word carries one entry only |
| host_wdata | input | 32 | Host write word |
| host_rd | input | 1 | Host read strobe |
| host_rdata | output | 32 | Host read word |
| status | output | 8 | Bit 6 tx full, bit 5 rx not empty, bit 4 tx not empty |
| blk_mode | output | 1 | Block mode selected |
| out_svc | output | 1 | Transmit block service pulse |
| in_svc | output | 1 | Receive block service pulse |
| eng_out_valid | output | 1 | Entry available to engine |
| eng_out_entry | output | 16 | Oldest transmit entry |
| eng_out_pop | input | 1 | Engine takes the entry |
| eng_in_push | input | 1 | Engine delivers a byte |
| eng_in_byte | input | 8 | Received byte |
| in_full | output | 1 | Receive queue full |

## Verification
The bench keeps the default codes: block code 0 and n = 1, which give two entries per block and a depth of eight. That depth is small enough to fill and drain both queues completely, so every full-flag boundary, the dropped write and the dropped push all occur. Every announced length from 0 to 15 is swept in both directions, which covers the mode switch points on each side. Service pulses are checked after every single pop and push.

// File: rtl/tpp_pkg.sv
package tpp_pkg;
    function automatic int blk_words(input int code);
        case (code)
            0:       return 4;
            1:       return 16;
            default: return 32;
        endcase
    endfunction

    function automatic int blk_entries(input int code);
        return blk_words(code) / 2;
    endfunction

    function automatic int q_depth(input int blk_code, input int fifo_code);
        return blk_entries(blk_code) * (2 << fifo_code);
    endfunction
endpackage

// File: rtl/tpp_blk_tick.sv
module tpp_blk_tick #(
    parameter int BLK = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       en,
    input  logic [1:0] ev,
    output logic       pulse
);
    localparam int CW = $clog2(BLK) + 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          pulse;
    } st_t;

    st_t q, d;
    logic [CW:0] sum;

    always_comb begin
        d       = q;
        d.pulse = 1'b0;
        sum     = {1'b0, q.cnt} + (CW+1)'(ev);
        if (clear) begin
            d.cnt = '0;
        end else if (en) begin
            if (sum >= (CW+1)'(BLK)) begin
                d.cnt   = CW'(sum - (CW+1)'(BLK));
                d.pulse = 1'b1;
            end else begin
                d.cnt = CW'(sum);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign pulse = q.pulse;
endmodule

// File: rtl/tpp_out_path.sv
module tpp_out_path #(
    parameter int DEPTH = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        repack_en,
    input  logic        wr,
    input  logic        wr_single,
    input  logic [31:0] wdata,
    input  logic        pop,
    output logic        full,
    output logic        not_empty,
    output logic [15:0] entry,
    output logic        popped
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    typedef struct packed {
        logic [DEPTH-1:0][15:0] mem;
        logic [AW-1:0]          wptr;
        logic [AW-1:0]          rptr;
        logic [CW-1:0]          cnt;
    } st_t;

    st_t q, d;
    logic take, one;
    logic [CW-1:0] n_in;

    always_comb begin
        d         = q;
        full      = repack_en ? (q.cnt > CW'(DEPTH - 2)) : (q.cnt == CW'(DEPTH));
        not_empty = (q.cnt != '0);
        popped    = pop && not_empty;
        one       = wr_single || !repack_en;
        take      = wr && !full;
        n_in      = '0;
        if (take) begin
            d.mem[q.wptr] = wdata[15:0];
            if (!one) d.mem[q.wptr + AW'(1)] = wdata[31:16];
            n_in   = one ? CW'(1) : CW'(2);
            d.wptr = q.wptr + AW'(n_in);
        end
        if (popped) d.rptr = q.rptr + AW'(1);
        d.cnt = q.cnt + n_in - CW'(popped);
        entry = q.mem[q.rptr];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/tpp_in_path.sv
module tpp_in_path #(
    parameter int DEPTH = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        repack_en,
    input  logic        push,
    input  logic [7:0]  din,
    input  logic        rd,
    output logic [31:0] rdata,
    output logic        not_empty,
    output logic        full,
    output logic        pushed
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    typedef struct packed {
        logic [DEPTH-1:0][7:0] mem;
        logic [AW-1:0]         wptr;
        logic [AW-1:0]         rptr;
        logic [CW-1:0]         cnt;
    } st_t;

    st_t q, d;
    logic two;
    logic [7:0] b0, b1;
    logic [CW-1:0] n_out;

    always_comb begin
        d         = q;
        not_empty = (q.cnt != '0);
        full      = (q.cnt == CW'(DEPTH));
        pushed    = push && !full;
        two       = repack_en && (q.cnt >= CW'(2));
        b0        = not_empty ? q.mem[q.rptr] : 8'h00;
        b1        = two ? q.mem[q.rptr + AW'(1)] : 8'h00;
        rdata     = {8'h00, b1, 8'h00, b0};
        n_out     = '0;
        if (rd && not_empty) n_out = two ? CW'(2) : CW'(1);
        if (pushed) begin
            d.mem[q.wptr] = din;
            d.wptr        = q.wptr + AW'(1);
        end
        d.rptr = q.rptr + AW'(n_out);
        d.cnt  = q.cnt + CW'(pushed) - n_out;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/tag_pack_port.sv
module tag_pack_port #(
    parameter int BLK_CODE  = 0,
    parameter int FIFO_CODE = 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        repack_en,
    input  logic        start,
    input  logic        start_is_read,
    input  logic [8:0]  start_bytes,
    input  logic        host_wr,
    input  logic        host_wr_single,
    input  logic [31:0] host_wdata,
    input  logic        host_rd,
    output logic [31:0] host_rdata,
    output logic [7:0]  status,
    output logic        blk_mode,
    output logic        out_svc,
    output logic        in_svc,
    output logic        eng_out_valid,
    output logic [15:0] eng_out_entry,
    input  logic        eng_out_pop,
    input  logic        eng_in_push,
    input  logic [7:0]  eng_in_byte,
    output logic        in_full
);
    localparam int BLK   = tpp_pkg::blk_entries(BLK_CODE);
    localparam int DEPTH = tpp_pkg::q_depth(BLK_CODE, FIFO_CODE);

    typedef struct packed {
        logic blk;
    } st_t;

    st_t q, d;
    logic [9:0] total;
    logic tx_full, tx_ne, rx_ne, popped, pushed;

    always_comb begin
        d     = q;
        total = start_is_read ? {1'b0, start_bytes} : ({1'b0, start_bytes} + 10'd1);
        if (start) d.blk = (total >= 10'(DEPTH));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    tpp_out_path #(.DEPTH(DEPTH)) u_out (
        .clk(clk), .rst_n(rst_n), .repack_en(repack_en),
        .wr(host_wr), .wr_single(host_wr_single), .wdata(host_wdata),
        .pop(eng_out_pop), .full(tx_full), .not_empty(tx_ne),
        .entry(eng_out_entry), .popped(popped)
    );

    tpp_in_path #(.DEPTH(DEPTH)) u_in (
        .clk(clk), .rst_n(rst_n), .repack_en(repack_en),
        .push(eng_in_push), .din(eng_in_byte), .rd(host_rd),
        .rdata(host_rdata), .not_empty(rx_ne), .full(in_full), .pushed(pushed)
    );

    tpp_blk_tick #(.BLK(BLK)) u_out_tick (
        .clk(clk), .rst_n(rst_n), .clear(start), .en(q.blk),
        .ev({1'b0, popped}), .pulse(out_svc)
    );

    tpp_blk_tick #(.BLK(BLK)) u_in_tick (
        .clk(clk), .rst_n(rst_n), .clear(start), .en(q.blk),
        .ev({1'b0, pushed}), .pulse(in_svc)
    );

    assign status        = {1'b0, tx_full, rx_ne, tx_ne, 4'b0000};
    assign blk_mode      = q.blk;
    assign eng_out_valid = tx_ne;
endmodule

// File: rtl/tag_pack_port_chk.sv
module tag_pack_port_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        host_wr,
    input logic        host_rd,
    input logic [7:0]  status,
    input logic        blk_mode,
    input logic        out_svc,
    input logic        in_svc,
    input logic        eng_out_pop,
    input logic        eng_in_push,
    input logic        in_full
);
    assert_full_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        status[6] && host_wr && !eng_out_pop |=> status[6]);

    assert_tx_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[4]) |-> $past(host_wr));

    assert_rx_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[5]) |-> $past(eng_in_push));

    assert_out_svc_mode_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !blk_mode && $past(!blk_mode) |-> !out_svc);

    assert_out_svc_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_svc |=> !out_svc);

    assert_in_svc_mode_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !blk_mode && $past(!blk_mode) |-> !in_svc);

    assert_in_svc_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        in_svc |=> !in_svc);

    assert_rx_full_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        in_full && eng_in_push && !host_rd |=> in_full);
endmodule

bind tag_pack_port tag_pack_port_chk u_chk (.*);

// File: tb/tag_pack_port_bench.sv
module tag_pack_port_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        repack_en = 1'b1;
    logic        start = 1'b0, start_is_read = 1'b0;
    logic [8:0]  start_bytes = '0;
    logic        host_wr = 1'b0, host_wr_single = 1'b0, host_rd = 1'b0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic [7:0]  status;
    logic        blk_mode, out_svc, in_svc, eng_out_valid, in_full;
    logic [15:0] eng_out_entry;
    logic        eng_out_pop = 1'b0, eng_in_push = 1'b0;
    logic [7:0]  eng_in_byte = '0;

    int compared = 0, mismatched = 0;
    bit done = 0;
    logic [15:0] tx_model[$];
    logic [7:0]  rx_model[$];
    int pops = 0, pushes = 0;

    localparam int DEPTH = 8;
    localparam int BLK   = 2;

    always #10 clk = ~clk;

    tag_pack_port u_tag_pack_port (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic announce(input bit rd, input int bytes);
        start = 1'b1; start_is_read = rd; start_bytes = 9'(bytes);
        @(negedge clk);
        start = 1'b0;
        pops = 0; pushes = 0;
    endtask

    task automatic wr_word(input logic [31:0] w, input bit single);
        bit one = single || !repack_en;
        bit exp_full = repack_en ? (tx_model.size() > DEPTH - 2) : (tx_model.size() == DEPTH);
        chk("R4 tx full", status[6], exp_full);
        host_wr = 1'b1; host_wr_single = single; host_wdata = w;
        @(negedge clk);
        host_wr = 1'b0; host_wr_single = 1'b0;
        if (!exp_full) begin
            tx_model.push_back(w[15:0]);
            if (!one) tx_model.push_back(w[31:16]);
        end
    endtask

    task automatic pop_one(input string req);
        chk("R5 tx not empty", status[4], 1'b1);
        chk(req, eng_out_entry, tx_model.pop_front());
        eng_out_pop = 1'b1;
        @(negedge clk);
        eng_out_pop = 1'b0;
        pops++;
        chk("R9 out_svc", out_svc, blk_mode && (pops % BLK == 0));
    endtask

    task automatic push_byte(input logic [7:0] b);
        bit exp_full = (rx_model.size() == DEPTH);
        chk("R12 in_full", in_full, exp_full);
        eng_in_push = 1'b1; eng_in_byte = b;
        @(negedge clk);
        eng_in_push = 1'b0;
        if (!exp_full) begin
            rx_model.push_back(b);
            pushes++;
            chk("R10 in_svc", in_svc, blk_mode && (pushes % BLK == 0));
        end
    endtask

    task automatic rd_word(input string req);
        logic [7:0] e0 = 8'h00, e1 = 8'h00;
        if (rx_model.size() > 0) e0 = rx_model.pop_front();
        if (repack_en && rx_model.size() > 0) e1 = rx_model.pop_front();
        chk(req, host_rdata, {8'h00, e1, 8'h00, e0});
        host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            mismatched++; compared++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk("R11 status", status, 8'h00);
        chk("R11 blk_mode", blk_mode, 1'b0);
        chk("R11 svc", {out_svc, in_svc}, 2'b00);
        chk("R11 valid", eng_out_valid, 1'b0);
        chk("R11 in_full", in_full, 1'b0);

        // R1 pair order, R4 full boundary and dropped write, R7 depth
        for (int i = 0; i < 5; i++)
            wr_word({8'hA0 + 8'(i), 8'(2*i+1), 8'h50 + 8'(i), 8'(2*i)}, 1'b0);
        while (tx_model.size() > 0) pop_one("R1 pair order");
        chk("R5 tx empty", status[4], 1'b0);

        // R2 single entries interleaved with pairs
        wr_word(32'hDEAD_1111, 1'b1);
        wr_word(32'h3333_2222, 1'b0);
        wr_word(32'hBEEF_4444, 1'b1);
        while (tx_model.size() > 0) pop_one("R2 single entry");

        // R3 repack off, R7 depth of eight single slots
        repack_en = 1'b0;
        for (int i = 0; i < 9; i++) wr_word({16'hFFFF, 16'h0100 + 16'(i)}, 1'b0);
        while (tx_model.size() > 0) pop_one("R3 one entry per word");

        // R3 single-byte reads
        push_byte(8'h11); push_byte(8'h22);
        chk("R5 rx not empty", status[5], 1'b1);
        rd_word("R3 one byte per read");
        rd_word("R3 one byte per read");
        chk("R5 rx empty", status[5], 1'b0);
        repack_en = 1'b1;

        // R6 byte pairs, odd tail; R12 full and dropped push
        for (int i = 0; i < 9; i++) push_byte(8'h30 + 8'(i * 7));
        chk("R12 in_full at depth", in_full, 1'b1);
        for (int i = 0; i < 4; i++) rd_word("R6 pair read");
        push_byte(8'h9C);
        push_byte(8'h5A);
        push_byte(8'hC3);
        rd_word("R6 pair read");
        rd_word("R6 lone byte read");
        chk("R6 drained", status[5], 1'b0);

        // R8 mode sweep both directions
        for (int b = 0; b < 16; b++) begin
            announce(1'b0, b);
            chk("R8 write mode", blk_mode, (b + 1) >= DEPTH);
            announce(1'b1, b);
            chk("R8 read mode", blk_mode, b >= DEPTH);
        end

        // R9 block-mode transmit service
        announce(1'b0, 10);
        for (int i = 0; i < 3; i++) wr_word(32'h0200_0100 + 32'(i), 1'b0);
        while (tx_model.size() > 0) pop_one("R9 block pops");
        announce(1'b0, 2);
        wr_word(32'h0AAA_0555, 1'b0);
        while (tx_model.size() > 0) pop_one("R9 queue-mode pops");

        // R10 block-mode receive service
        announce(1'b1, 12);
        for (int i = 0; i < 5; i++) push_byte(8'h70 + 8'(i));
        while (rx_model.size() > 0) rd_word("R10 drain");
        announce(1'b1, 3);
        for (int i = 0; i < 2; i++) push_byte(8'h40 + 8'(i));
        while (rx_model.size() > 0) rd_word("R10 drain");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule